// File: doc/BRIEF.md
# Multi-Lane SPI Master

This block is the master end of a synchronous serial link that moves characters over one, two or four data lanes. It always drives the serial clock and the slave select. In single-lane mode a transfer can be full duplex (data out on lane 0, data in on lane 1) or half duplex. In dual and quad mode every transfer is half duplex, and a direction input chooses whether the lanes carry data out or data in. Characters are sent and received most significant bit first.

Software, or a DMA engine, fills a transmit FIFO and drains a receive FIFO. Each FIFO raises a request line when it needs service, compared against a threshold set by the user. A transfer begins with a one-cycle start pulse. It latches the configuration and then holds slave select active for a programmed number of characters. The serial clock idles low and runs at the module clock divided by an even, programmable factor.

Top module: `spi_ml_master`

## Requirements
- R1: `cfg_lanes` picks the lane width: 0 gives one lane, 1 gives two lanes, 2 gives four lanes, and 3 is reserved. Data moves MSB first. In single-lane mode the output bit is on lane 0 and the input bit is on lane 1. In dual mode the earlier bit of each pair is on lane 1. In quad mode the earliest bit of each nibble is on lane 3.
- R2: When `cfg_full_duplex`=1 and the mode is single-lane, each character popped from the transmit FIFO is shifted out on lane 0. In the same SCLK cycles, one character is assembled from lane 1 and pushed into the receive FIFO.
- R3: In a half-duplex transfer, `cfg_dir_tx`=1 sends data and sets `lane_oe` on exactly the lanes in use. In that case nothing is pushed into the receive FIFO. `cfg_dir_tx`=0 receives data with `lane_oe` all zero. Outside a transfer, `lane_oe` is zero.
- R4: A start request with `cfg_full_duplex`=1 in dual or quad mode, or with the reserved lane code, is ignored: slave select and SCLK stay idle. Such a request sets `err_mode`. The next accepted start clears it.
- R5: SCLK idles low. Output lanes change only on falling SCLK edges and stay stable while SCLK is high. Input lanes are sampled at the rising edge.
- R6: Each SCLK high phase and low phase lasts `cfg_div`+1 module clock cycles. Slave select becomes active `cfg_div`+1 cycles before the first rising SCLK edge, and becomes inactive `cfg_div`+1 cycles after the last falling edge.
- R7: Slave select is at level `cfg_ss_high` while active and at the inverse level while idle.
- R8: A transfer carries exactly `cfg_chars`+1 characters with slave select held active throughout, which is (`cfg_chars`+1)·W/lanes rising SCLK edges.
- R9: `dma_tx_req` is high while the transmit FIFO holds fewer than `cfg_tx_thresh` entries. `dma_rx_req` is high while the receive FIFO holds at least `cfg_rx_thresh` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request, taken only while idle |
| cfg_lanes | input | 2 | Lane width code (0: x1, 1: x2, 2: x4, 3: reserved) |
| cfg_full_duplex | input | 1 | Request a full-duplex transfer (single lane only) |
| cfg_dir_tx | input | 1 | Half-duplex direction: 1 transmit, 0 receive |
| cfg_ss_high | input | 1 | Active level of slave select |
| cfg_div | input | DIV_W | SCLK half period minus one, in module clocks |
| cfg_chars | input | CNT_W | Characters per transfer minus one |
| cfg_tx_thresh | input | $clog2(DEPTH)+1 | Transmit request threshold |
| cfg_rx_thresh | input | $clog2(DEPTH)+1 | Receive request threshold |
| tx_push | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | input | W | Transmit character |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | W | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| dma_tx_req | output | 1 | Transmit FIFO below threshold |
| dma_rx_req | output | 1 | Receive FIFO at or above threshold |
| busy | output | 1 | Transfer in progress |
| err_mode | output | 1 | Last start was refused as an illegal mode |
| sclk | output | 1 | Serial clock |
| ss | output | 1 | Slave select |
| lane_out | output | 4 | Output values of the data lanes |
| lane_oe | output | 4 | Output enables of the data lanes |
| lane_in | input | 4 | Input values of the data lanes |

## Verification
Suppose the beat counter or the lane-width decode inside the engine goes wrong. Every later character then comes out rotated or shifted, and the error is visible at the slave model on the first character boundary that follows. A fault in the half-period divider appears as a wrong count of module cycles within the first SCLK phase, or even in the slave-select lead time, before any data moves. A fault in the character counter, or in the latched polarity, appears only when slave select falls. For that reason the bench checks the number of edges and the slave-select levels on every transfer, and not just the data.

// File: rtl/spi_ml_pkg.sv
package spi_ml_pkg;

    typedef enum logic [1:0] {
        LN_X1   = 2'd0,
        LN_X2   = 2'd1,
        LN_X4   = 2'd2,
        LN_RSVD = 2'd3
    } lanes_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } eng_st_e;

    // Configuration captured when a transfer is accepted.
    typedef struct packed {
        lanes_e lanes;
        logic   tx_en;
        logic   rx_en;
        logic   ss_high;
    } xfer_cfg_t;

    function automatic logic mode_legal(lanes_e l, logic full_dup);
        return (l != LN_RSVD) && !(full_dup && (l != LN_X1));
    endfunction

    function automatic logic [3:0] lane_mask(lanes_e l);
        case (l)
            LN_X1:   return 4'b0001;
            LN_X2:   return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/spi_ml_fifo.sv
module spi_ml_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [W-1:0]             wdata,
    input  logic                     pop,
    output logic [W-1:0]             head,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/spi_ml_clkgen.sv
module spi_ml_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_ml_engine.sv
module spi_ml_engine
    import spi_ml_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       cfg_lanes,
    input  logic             cfg_full_duplex,
    input  logic             cfg_dir_tx,
    input  logic             cfg_ss_high,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_chars,
    input  logic             tick,
    output logic             half_en,
    output logic [DIV_W-1:0] div_q,
    input  logic [W-1:0]     tx_word,
    input  logic             tx_avail,
    output logic             tx_take,
    output logic [W-1:0]     rx_word,
    output logic             rx_put,
    input  logic [3:0]       lane_in,
    output logic [3:0]       lane_out,
    output logic [3:0]       lane_oe,
    output logic             sclk,
    output logic             ss,
    output logic             busy,
    output logic             err
);
    localparam int BW = $clog2(W) + 1;

    eng_st_e          state;
    xfer_cfg_t        cfg_q, cfg_new;
    logic [CNT_W-1:0] chars_q, chr_cnt;
    logic [BW-1:0]    beat, last_beat;
    logic [W-1:0]     tx_sh, rx_sh, tx_next, rx_next, load_word;
    logic             sclk_q, err_q, idle, accept, reject;
    logic             end_char, load_next, next_tx_en, pol;

    assign idle    = (state == ST_IDLE);
    assign accept  = start && idle && mode_legal(lanes_e'(cfg_lanes), cfg_full_duplex);
    assign reject  = start && idle && !mode_legal(lanes_e'(cfg_lanes), cfg_full_duplex);

    always_comb begin
        cfg_new.lanes   = lanes_e'(cfg_lanes);
        cfg_new.tx_en   = cfg_full_duplex || cfg_dir_tx;
        cfg_new.rx_en   = cfg_full_duplex || !cfg_dir_tx;
        cfg_new.ss_high = cfg_ss_high;
    end

    assign last_beat  = BW'(W >> cfg_q.lanes) - BW'(1);
    assign end_char   = (state == ST_HIGH) && tick && (beat == last_beat);
    assign load_next  = end_char && (chr_cnt != chars_q);
    assign next_tx_en = accept ? cfg_new.tx_en : cfg_q.tx_en;
    assign tx_take    = (accept || load_next) && next_tx_en && tx_avail;
    assign load_word  = (next_tx_en && tx_avail) ? tx_word : '0;

    assign rx_put  = end_char && cfg_q.rx_en;
    assign rx_word = rx_sh;

    // Shift paths by lane width: MSB leaves first, highest lane carries it.
    always_comb begin
        case (cfg_q.lanes)
            LN_X1: begin
                tx_next = {tx_sh[W-2:0], 1'b0};
                rx_next = {rx_sh[W-2:0], lane_in[1]};
            end
            LN_X2: begin
                tx_next = {tx_sh[W-3:0], 2'b00};
                rx_next = {rx_sh[W-3:0], lane_in[1:0]};
            end
            default: begin
                tx_next = {tx_sh[W-5:0], 4'b0000};
                rx_next = {rx_sh[W-5:0], lane_in};
            end
        endcase
    end

    always_comb begin
        lane_out = 4'b0000;
        if (!idle && cfg_q.tx_en) begin
            case (cfg_q.lanes)
                LN_X1:   lane_out = {3'b000, tx_sh[W-1]};
                LN_X2:   lane_out = {2'b00, tx_sh[W-1:W-2]};
                default: lane_out = tx_sh[W-1:W-4];
            endcase
        end
    end

    assign lane_oe = (!idle && cfg_q.tx_en) ? lane_mask(cfg_q.lanes) : 4'b0000;
    assign pol     = idle ? cfg_ss_high : cfg_q.ss_high;
    assign ss      = ~(!idle ^ pol);
    assign sclk    = sclk_q;
    assign busy    = !idle;
    assign half_en = !idle;
    assign err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            div_q   <= '0;
            chars_q <= '0;
            chr_cnt <= '0;
            beat    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q   <= cfg_new;
                        div_q   <= cfg_div;
                        chars_q <= cfg_chars;
                        chr_cnt <= '0;
                        beat    <= '0;
                        tx_sh   <= load_word;
                        err_q   <= 1'b0;
                        state   <= ST_LEAD;
                    end else if (reject) begin
                        err_q <= 1'b1;
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= rx_next;
                        state  <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        if (beat == last_beat) begin
                            beat <= '0;
                            if (chr_cnt == chars_q) begin
                                state <= ST_TAIL;
                            end else begin
                                chr_cnt <= chr_cnt + 1'b1;
                                tx_sh   <= load_word;
                                state   <= ST_LOW;
                            end
                        end else begin
                            beat  <= beat + 1'b1;
                            tx_sh <= tx_next;
                            state <= ST_LOW;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_ml_master.sv
module spi_ml_master
    import spi_ml_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [1:0]             cfg_lanes,
    input  logic                   cfg_full_duplex,
    input  logic                   cfg_dir_tx,
    input  logic                   cfg_ss_high,
    input  logic [DIV_W-1:0]       cfg_div,
    input  logic [CNT_W-1:0]       cfg_chars,
    input  logic [$clog2(DEPTH):0] cfg_tx_thresh,
    input  logic [$clog2(DEPTH):0] cfg_rx_thresh,
    input  logic                   tx_push,
    input  logic [W-1:0]           tx_data,
    output logic                   tx_full,
    input  logic                   rx_pop,
    output logic [W-1:0]           rx_data,
    output logic                   rx_empty,
    output logic                   dma_tx_req,
    output logic                   dma_rx_req,
    output logic                   busy,
    output logic                   err_mode,
    output logic                   sclk,
    output logic                   ss,
    output logic [3:0]             lane_out,
    output logic [3:0]             lane_oe,
    input  logic [3:0]             lane_in
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic [W-1:0]     tx_head, rx_word;
    logic             tx_empty, tx_take, rx_put, rx_full;
    logic             tick, half_en;
    logic [DIV_W-1:0] div_q;

    spi_ml_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .wdata(tx_data), .pop(tx_take),
        .head(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spi_ml_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_put), .wdata(rx_word), .pop(rx_pop),
        .head(rx_data), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spi_ml_clkgen #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .en(half_en), .div(div_q), .tick(tick)
    );

    spi_ml_engine #(.W(W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .start(start),
        .cfg_lanes(cfg_lanes), .cfg_full_duplex(cfg_full_duplex),
        .cfg_dir_tx(cfg_dir_tx), .cfg_ss_high(cfg_ss_high),
        .cfg_div(cfg_div), .cfg_chars(cfg_chars),
        .tick(tick), .half_en(half_en), .div_q(div_q),
        .tx_word(tx_head), .tx_avail(!tx_empty), .tx_take(tx_take),
        .rx_word(rx_word), .rx_put(rx_put),
        .lane_in(lane_in), .lane_out(lane_out), .lane_oe(lane_oe),
        .sclk(sclk), .ss(ss), .busy(busy), .err(err_mode)
    );

    assign dma_tx_req = (tx_cnt < cfg_tx_thresh);
    assign dma_rx_req = (rx_cnt >= cfg_rx_thresh);

endmodule

// File: rtl/spi_ml_checker.sv
module spi_ml_checker #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [1:0]    cfg_lanes,
    input logic          cfg_full_duplex,
    input logic [TW-1:0] cfg_rx_thresh,
    input logic          rx_empty,
    input logic          dma_rx_req,
    input logic          busy,
    input logic          err_mode,
    input logic          sclk,
    input logic          ss,
    input logic [3:0]    lane_oe
);

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    p_oe_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_oe == 4'b0000));

    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_full_duplex && (cfg_lanes != 2'd0)) |=> (err_mode && !busy));

    p_ss_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ss));

    p_edge_in_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> busy);

    p_rx_req_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && (cfg_rx_thresh != '0)) |-> !dma_rx_req);

endmodule

bind spi_ml_master spi_ml_checker #(.TW($bits(cfg_rx_thresh))) u_chk (
    .clk(clk), .rst(rst), .start(start),
    .cfg_lanes(cfg_lanes), .cfg_full_duplex(cfg_full_duplex),
    .cfg_rx_thresh(cfg_rx_thresh), .rx_empty(rx_empty),
    .dma_rx_req(dma_rx_req), .busy(busy), .err_mode(err_mode),
    .sclk(sclk), .ss(ss), .lane_oe(lane_oe)
);

// File: tb/tb_spi_ml_master.sv
`timescale 1ns/1ps
module tb_spi_ml_master;
    localparam int W     = 8;
    localparam int DEPTH = 8;
    localparam int DIV_W = 8;
    localparam int CNT_W = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       cfg_lanes = 2'd0;
    logic             cfg_full_duplex = 1'b0;
    logic             cfg_dir_tx = 1'b0;
    logic             cfg_ss_high = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [CNT_W-1:0] cfg_chars = '0;
    logic [CW-1:0]    cfg_tx_thresh = '0;
    logic [CW-1:0]    cfg_rx_thresh = '0;
    logic             tx_push = 1'b0;
    logic [W-1:0]     tx_data = '0;
    logic             tx_full;
    logic             rx_pop = 1'b0;
    logic [W-1:0]     rx_data;
    logic             rx_empty, dma_tx_req, dma_rx_req, busy, err_mode, sclk, ss;
    logic [3:0]       lane_out, lane_oe;
    logic [3:0]       lane_in = 4'b0000;

    spi_ml_master #(.W(W), .DEPTH(DEPTH), .DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_lanes(cfg_lanes), .cfg_full_duplex(cfg_full_duplex),
        .cfg_dir_tx(cfg_dir_tx), .cfg_ss_high(cfg_ss_high),
        .cfg_div(cfg_div), .cfg_chars(cfg_chars),
        .cfg_tx_thresh(cfg_tx_thresh), .cfg_rx_thresh(cfg_rx_thresh),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .busy(busy), .err_mode(err_mode), .sclk(sclk), .ss(ss),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // ---------------- behavioural slave, sampled away from the clock edge
    logic [W-1:0] s_words [16];
    logic [W-1:0] m_words [16];
    logic [W-1:0] pushed  [16];
    logic [W-1:0] m_acc;
    int  s_lanes = 0, s_div = 0, s_beat = 0, s_chr = 0, rises = 0;
    bit  s_pol = 0, act_p = 0, sclk_p = 0, first_seen = 0;
    bit  timing_bad = 0, stab_bad = 0, oe_bad = 0;
    int  t_on = 0, t_first = 0, t_lrise = 0, t_lfall = 0, t_off = 0;
    logic [3:0] out_p = 4'b0, exp_oe = 4'b0;

    function automatic logic [3:0] drive(logic [W-1:0] w, int b);
        int bpc = 1 << s_lanes;
        int v   = (int'(w) >> (W - bpc * (b + 1))) & ((1 << bpc) - 1);
        if (s_lanes == 0) return {2'b00, v[0], 1'b0};
        return v[3:0];
    endfunction

    always @(negedge clk) begin
        bit act;
        int bpc;
        cyc++;
        bpc = 1 << s_lanes;
        act = (ss == s_pol);
        if (act && !act_p) begin
            t_on = cyc; s_beat = 0; s_chr = 0; rises = 0; m_acc = '0; first_seen = 0;
            lane_in <= drive(s_words[0], 0);
        end
        if (busy && (lane_oe != exp_oe)) oe_bad = 1;
        if (sclk && !sclk_p) begin
            rises++;
            if (!first_seen) begin
                first_seen = 1;
                t_first = cyc;
            end else if (cyc - t_lfall != s_div + 1) timing_bad = 1;
            t_lrise = cyc;
            case (s_lanes)
                0:       m_acc = {m_acc[W-2:0], lane_out[0]};
                1:       m_acc = {m_acc[W-3:0], lane_out[1:0]};
                default: m_acc = {m_acc[W-5:0], lane_out};
            endcase
            s_beat++;
            if (s_beat == W / bpc) begin
                m_words[s_chr % 16] = m_acc;
                s_chr++;
                s_beat = 0;
                m_acc = '0;
            end
        end
        if (sclk && sclk_p && (lane_out != out_p)) stab_bad = 1;
        if (!sclk && sclk_p) begin
            t_lfall = cyc;
            if (cyc - t_lrise != s_div + 1) timing_bad = 1;
            lane_in <= drive(s_words[s_chr % 16], s_beat);
        end
        if (!act && act_p) t_off = cyc;
        sclk_p = sclk;
        act_p  = act;
        out_p  = lane_out;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- one transfer, checked end to end
    task automatic xfer(int lanes, bit fd, bit dtx, bit pol, int div, int nch,
                        int txth, int rxth, bit prefilled);
        bit txe = fd || dtx;
        bit rxe = fd || !dtx;
        int bpc = 1 << lanes;
        int g;
        step();
        cfg_ss_high = pol; s_pol = pol; s_lanes = lanes; s_div = div;
        exp_oe = txe ? ((lanes == 0) ? 4'b0001 : (lanes == 1) ? 4'b0011 : 4'b1111) : 4'b0000;
        timing_bad = 0; stab_bad = 0; oe_bad = 0;
        cfg_tx_thresh = CW'(txth);
        cfg_rx_thresh = CW'(rxth);
        step();
        chk(ss == !pol, "R7 idle level", ss, !pol);
        for (int i = 0; i < nch; i++) begin
            s_words[i] = W'($urandom);
            if (txe && !prefilled) begin
                pushed[i] = W'($urandom);
                tx_data = pushed[i];
                tx_push = 1'b1;
                step();
                tx_push = 1'b0;
            end
        end
        step();
        chk(dma_tx_req == ((txe ? nch : 0) < txth), "R9 tx request", dma_tx_req, (txe ? nch : 0) < txth);
        cfg_lanes = 2'(lanes); cfg_full_duplex = fd; cfg_dir_tx = dtx;
        cfg_div = DIV_W'(div); cfg_chars = CNT_W'(nch - 1);
        start = 1'b1;
        step();
        start = 1'b0;
        g = 0;
        while (busy && g < 20000) begin
            step();
            g++;
        end
        step();
        step();
        chk(t_first - t_on == div + 1, "R6 lead", t_first - t_on, div + 1);
        chk(t_off - t_lfall == div + 1, "R6 trail", t_off - t_lfall, div + 1);
        chk(!timing_bad, "R6 phase width", timing_bad, 0);
        chk(rises == nch * (W / bpc), "R8 edge count", rises, nch * (W / bpc));
        chk(!stab_bad, "R5 output stable while high", stab_bad, 0);
        chk(!oe_bad, "R3 output enables", oe_bad, 0);
        chk(ss == !pol && !sclk, "R7 ss returns idle", ss, !pol);
        if (txe)
            for (int i = 0; i < nch; i++)
                chk(m_words[i] == pushed[i], fd ? "R2 full-duplex out" : "R1 lane order out",
                    m_words[i], pushed[i]);
        if (rxe) begin
            chk(dma_rx_req == (nch >= rxth), "R9 rx request", dma_rx_req, nch >= rxth);
            for (int i = 0; i < nch; i++) begin
                chk(!rx_empty && rx_data == s_words[i], fd ? "R2 full-duplex in" : "R1 lane order in",
                    rx_data, s_words[i]);
                rx_pop = 1'b1;
                step();
                rx_pop = 1'b0;
            end
        end
        chk(rx_empty, "R3 receive queue drained or untouched", rx_empty, 1);
    endtask

    task automatic refused(int lanes, bit fd);
        bit moved = 0;
        step();
        cfg_lanes = 2'(lanes); cfg_full_duplex = fd; cfg_dir_tx = 1'b1;
        start = 1'b1;
        step();
        start = 1'b0;
        chk(err_mode && !busy, "R4 refusal flag", err_mode, 1);
        for (int i = 0; i < 12; i++) begin
            if (busy || sclk || ss == cfg_ss_high) moved = 1;
            step();
        end
        chk(!moved, "R4 bus stays idle", moved, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        rst = 1'b0;
        step();
        // reset state
        chk(!sclk && !busy && lane_oe == 4'b0, "R5 reset idle", {sclk, busy}, 0);
        chk(ss == 1'b1, "R7 reset idle active-low", ss, 1);
        chk(rx_empty && !tx_full && !err_mode, "R9 reset queues", {rx_empty, tx_full}, 2);

        // directed R9 with prefilled transmit queue
        cfg_tx_thresh = CW'(2);
        step();
        chk(dma_tx_req, "R9 tx request empty", dma_tx_req, 1);
        for (int i = 0; i < 2; i++) begin
            pushed[i] = W'(8'hA5 ^ i);
            tx_data = pushed[i];
            tx_push = 1'b1;
            step();
            tx_push = 1'b0;
            step();
            chk(dma_tx_req == (i == 0), "R9 tx request fill", dma_tx_req, i == 0);
        end
        xfer(0, 0, 1, 0, 0, 2, 2, 1, 1);

        // directed corners
        xfer(2, 0, 1, 1, 0, 3, 1, 1, 0);   // quad out, fastest clock
        xfer(2, 0, 0, 0, 2, 3, 1, 3, 0);   // quad in, rx threshold met
        xfer(1, 0, 1, 0, 1, 2, 4, 1, 0);   // dual out
        xfer(1, 0, 0, 1, 0, 4, 1, 5, 0);   // dual in, below threshold
        xfer(0, 1, 0, 0, 5, 1, 1, 1, 0);   // single full duplex, slow
        xfer(0, 1, 1, 1, 0, 8, 8, 8, 0);   // full queue depth
        xfer(0, 0, 0, 0, 3, 2, 0, 0, 0);   // single receive only

        // refused modes
        refused(2, 1);
        refused(1, 1);
        refused(3, 0);
        xfer(0, 0, 1, 0, 0, 1, 1, 1, 0);
        chk(!err_mode, "R4 cleared by accepted start", err_mode, 0);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int ln = $urandom % 3;
            bit fd = (ln == 0) ? bit'($urandom % 2) : 1'b0;
            xfer(ln, fd, bit'($urandom % 2), bit'($urandom % 2), $urandom % 4,
                 1 + $urandom % 6, $urandom % 9, $urandom % 9, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule